// File: doc/BRIEF.md
# Single-Sector Storage Task-File Sequencer

This block puts a hardware state machine in place of a software driver for a removable flash storage device. The device is reached through the eight-register ATA task file, eight bits wide. A host asks for one of three jobs with a single-cycle start pulse. An init job brings the device up: the block waits for the device to report ready, selects byte-wide transfers and switches off the write cache. A read or write job moves one 512-byte sector, using logical block addressing, between the device data register and a local byte buffer.

The host sees busy while a job runs. When the job ends, done pulses for one cycle. At that point ok and an eight-bit error code hold the result, and they stay valid until the next start. The device's own error register supplies the code, except that the block keeps three codes of its own. These cover the device never coming up, the device staying stalled after init, and the device flagging an error while its error register reads zero. The poll spacing during init and the stall limit are counted in clock cycles and set by parameters.

Top module: `ata_xfer_ctrl`

## Requirements
- R1: While reset is held and straight after it, busy, done and ok are 0, err_code is 0x00, and no task-file or buffer strobe is asserted.
- R2: An init job (op 0) first writes CMD_INIT to task-file offset 7. It then reads the status at offset 7, where bit 7 is busy and bit 6 is ready, until busy is 0 and ready is 1. Next it writes 0x01 to offset 1 and 0xEF to offset 7, and waits for ready. It then writes 0x82 to offset 1 and 0xEF to offset 7, waits for ready again, and ends with ok=1.
- R3: During init, the block polls the status POLL_TRIES times (256 by default) at most, with successive polls exactly POLL_GAP+1 cycles apart. If none of those polls sees ready, the job ends with ok=0, err_code 0xFE, and no further task-file write after the first command.
- R4: A read (op 1) or write (op 2) job first waits for ready. It then writes, in this order: 0xE0 to offset 6, block[23:16] to offset 5, block[15:8] to offset 4, block[7:0] to offset 3, and 0x01 to offset 2. block[31:24] has no effect. The task-file read and write strobes are never both high.
- R5: A read job writes 0x20 to offset 7 and waits until busy is 0 and data-request (status bit 3) is 1. With the error bit (status bit 0) clear, it makes 512 reads of offset 0. On each of these cycles it stores the byte read to buffer addresses 0, 1, ... 511 in turn, and it then ends with ok=1 and err_code 0.
- R6: A write job writes 0x30 to offset 7 and waits for data-request. It then writes buffer bytes 0 to 511 in order to offset 0, waits for ready, and with status bit 0 clear ends with ok=1 and err_code 0.
- R7: If status bit 0 is set when data-request is seen, the block reads offset 1. The job ends with ok=0 and err_code equal to that byte, and no data byte is moved.
- R8: If the byte read from offset 1 on an error is 0x00, err_code is 0xFF. A failed job never reports err_code 0x00.
- R9: If status bit 0 is set at the ready check after a write's data phase, the block reads offset 1 and reports that byte, even though all 512 bytes were moved.
- R10: If a ready or data-request wait after the start of a job runs for WAIT_LIMIT cycles without success, the job ends with ok=0 and err_code 0xFD.
- R11: busy is 1 from the cycle after start until done. done is a single-cycle pulse. While busy is 0, no strobe is asserted.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| start | input | 1 | Start pulse, taken while idle |
| op | input | 2 | Job: 0 init, 1 read, 2 write |
| block | input | 32 | Block number; bits 31:24 ignored |
| busy | output | 1 | Job in progress |
| done | output | 1 | One-cycle end-of-job pulse |
| ok | output | 1 | Last job succeeded |
| err_code | output | 8 | Last job's failure code, 0 on success |
| tf_addr | output | 3 | Task-file register offset |
| tf_wr | output | 1 | Task-file write strobe |
| tf_rd | output | 1 | Task-file read strobe, data sampled same cycle |
| tf_wdata | output | 8 | Task-file write data |
| tf_rdata | input | 8 | Task-file read data |
| buf_addr | output | 9 | Buffer byte address |
| buf_wr | output | 1 | Buffer write strobe (read job) |
| buf_wdata | output | 8 | Buffer write data |
| buf_rd | output | 1 | Buffer read strobe (write job) |
| buf_rdata | input | 8 | Buffer read data, valid same cycle |

## Verification
The bench aims first at the init give-up path. It counts exactly 256 polls and measures every poll gap, so an off-by-one in the attempt count or the delay shows up as 255 or 257 polls or a wrong spacing. It then compares every task-file write against the expected ordered list. That catches a transposed block byte, a leaked top byte or a missed wait, all of which would hand the device the wrong sector. Error paths are forced one by one: an error with data-request, an error register that reads zero (a design without the substitution would report success-looking 0x00), an error after the write data phase (a design that skipped the second check would report ok), and a device that never raises data-request (a design without the stall limit would hang).

// File: rtl/ata_pkg.sv
package ata_pkg;
    localparam logic [1:0] OP_INIT  = 2'd0;
    localparam logic [1:0] OP_READ  = 2'd1;
    localparam logic [1:0] OP_WRITE = 2'd2;

    localparam logic [2:0] REG_DATA  = 3'd0;
    localparam logic [2:0] REG_FEAT  = 3'd1;
    localparam logic [2:0] REG_COUNT = 3'd2;
    localparam logic [2:0] REG_LBA0  = 3'd3;
    localparam logic [2:0] REG_LBA1  = 3'd4;
    localparam logic [2:0] REG_LBA2  = 3'd5;
    localparam logic [2:0] REG_DRV   = 3'd6;
    localparam logic [2:0] REG_CMD   = 3'd7;

    localparam logic [7:0] CODE_NO_READY = 8'hFE;
    localparam logic [7:0] CODE_STALL    = 8'hFD;
    localparam logic [7:0] CODE_ZERO_ERR = 8'hFF;

    typedef enum logic [3:0] {
        S_IDLE, S_ICMD, S_IPOLL, S_IDLY, S_FEAT, S_SETF,
        S_WAIT, S_LBA, S_CMD, S_XFER, S_ERRRD
    } state_e;

    typedef enum logic [2:0] {
        A_FEAT1, A_FEAT2, A_LBA, A_DRQ, A_POST
    } after_e;
endpackage

// File: rtl/ata_status_decode.sv
module ata_status_decode (
    input  logic [7:0] status,
    output logic       ready,
    output logic       drq,
    output logic       err
);
    logic bsy;
    logic unused_bits;

    always_comb begin
        bsy   = status[7];
        ready = !bsy && status[6];
        drq   = !bsy && status[3];
        err   = !bsy && status[0];
    end

    assign unused_bits = ^{status[5:4], status[2:1]};
endmodule

// File: rtl/ata_gap_timer.sv
module ata_gap_timer #(
    parameter int W = 8
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic         clr,
    input  logic [W-1:0] limit,
    output logic         expired
);
    logic [W-1:0] cnt_d, cnt_q;

    always_comb begin
        expired = (cnt_q == limit - W'(1));
        cnt_d   = cnt_q;
        if (clr)
            cnt_d = '0;
        else if (!expired)
            cnt_d = cnt_q + W'(1);
    end

    always_ff @(posedge clk) begin
        if (!rst_n) cnt_q <= '0;
        else        cnt_q <= cnt_d;
    end
endmodule

// File: rtl/ata_xfer_ctrl.sv
module ata_xfer_ctrl
    import ata_pkg::*;
#(
    parameter int         POLL_TRIES   = 256,
    parameter int         POLL_GAP     = 2000000,
    parameter int         WAIT_LIMIT   = 1000000,
    parameter int         SECTOR_BYTES = 512,
    parameter logic [7:0] CMD_INIT     = 8'hE1,
    parameter logic [7:0] CMD_READ     = 8'h20,
    parameter logic [7:0] CMD_WRITE    = 8'h30,
    parameter logic [7:0] CMD_SETFEAT  = 8'hEF,
    parameter logic [7:0] FEAT_BYTE    = 8'h01,
    parameter logic [7:0] FEAT_NOCACHE = 8'h82,
    localparam int        AW = $clog2(SECTOR_BYTES)
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          start,
    input  logic [1:0]    op,
    input  logic [31:0]   block,
    output logic          busy,
    output logic          done,
    output logic          ok,
    output logic [7:0]    err_code,
    output logic [2:0]    tf_addr,
    output logic          tf_wr,
    output logic          tf_rd,
    output logic [7:0]    tf_wdata,
    input  logic [7:0]    tf_rdata,
    output logic [AW-1:0] buf_addr,
    output logic          buf_wr,
    output logic [7:0]    buf_wdata,
    output logic          buf_rd,
    input  logic [7:0]    buf_rdata
);
    localparam int TRW  = $clog2(POLL_TRIES);
    localparam int TMAX = (POLL_GAP > WAIT_LIMIT) ? POLL_GAP : WAIT_LIMIT;
    localparam int TW   = $clog2(TMAX + 1);

    typedef struct packed {
        state_e          st;
        after_e          aft;
        logic [2:0]      sub;
        logic [TRW-1:0]  tries;
        logic [AW-1:0]   idx;
        logic            wr_op;
        logic [23:0]     lba;
        logic            done;
        logic            ok;
        logic [7:0]      code;
    } ctl_t;

    ctl_t q, d;
    logic st_ready, st_drq, st_err;
    logic tmr_clr, tmr_exp;
    logic [TW-1:0] tmr_limit;
    logic unused_top;

    assign unused_top = ^block[31:24];

    ata_status_decode u_dec (
        .status (tf_rdata),
        .ready  (st_ready),
        .drq    (st_drq),
        .err    (st_err)
    );

    assign tmr_clr   = !(q.st == S_IDLY || q.st == S_WAIT);
    assign tmr_limit = (q.st == S_IDLY) ? TW'(POLL_GAP) : TW'(WAIT_LIMIT);

    ata_gap_timer #(.W(TW)) u_tmr (
        .clk     (clk),
        .rst_n   (rst_n),
        .clr     (tmr_clr),
        .limit   (tmr_limit),
        .expired (tmr_exp)
    );

    always_comb begin
        d         = q;
        d.done    = 1'b0;
        tf_addr   = REG_CMD;
        tf_wr     = 1'b0;
        tf_rd     = 1'b0;
        tf_wdata  = 8'h00;
        buf_addr  = q.idx;
        buf_wr    = 1'b0;
        buf_rd    = 1'b0;
        buf_wdata = tf_rdata;
        case (q.st)
            S_IDLE: if (start) begin
                d.wr_op = (op == OP_WRITE);
                d.lba   = block[23:0];
                d.ok    = 1'b0;
                d.code  = 8'h00;
                d.tries = '0;
                d.sub   = '0;
                d.idx   = '0;
                if (op == OP_READ || op == OP_WRITE) begin
                    d.st  = S_WAIT;
                    d.aft = A_LBA;
                end else begin
                    d.st  = S_ICMD;
                end
            end
            S_ICMD: begin
                tf_wr    = 1'b1;
                tf_wdata = CMD_INIT;
                d.st     = S_IPOLL;
            end
            S_IPOLL: begin
                tf_rd = 1'b1;
                if (st_ready) begin
                    d.st  = S_FEAT;
                    d.sub = '0;
                end else if (q.tries == TRW'(POLL_TRIES - 1)) begin
                    d.st   = S_IDLE;
                    d.done = 1'b1;
                    d.code = CODE_NO_READY;
                end else begin
                    d.tries = q.tries + TRW'(1);
                    d.st    = S_IDLY;
                end
            end
            S_IDLY: if (tmr_exp) d.st = S_IPOLL;
            S_FEAT: begin
                tf_wr    = 1'b1;
                tf_addr  = REG_FEAT;
                tf_wdata = q.sub[0] ? FEAT_NOCACHE : FEAT_BYTE;
                d.st     = S_SETF;
            end
            S_SETF: begin
                tf_wr    = 1'b1;
                tf_wdata = CMD_SETFEAT;
                d.st     = S_WAIT;
                d.aft    = q.sub[0] ? A_FEAT2 : A_FEAT1;
            end
            S_WAIT: begin
                tf_rd = 1'b1;
                if ((q.aft == A_DRQ) ? st_drq : st_ready) begin
                    case (q.aft)
                        A_FEAT1: begin d.st = S_FEAT; d.sub = 3'd1; end
                        A_LBA:   begin d.st = S_LBA;  d.sub = '0;   end
                        A_DRQ, A_POST: begin
                            if (st_err)               d.st = S_ERRRD;
                            else if (q.aft == A_DRQ)  d.st = S_XFER;
                            else begin d.st = S_IDLE; d.done = 1'b1; d.ok = 1'b1; end
                        end
                        default: begin d.st = S_IDLE; d.done = 1'b1; d.ok = 1'b1; end
                    endcase
                end else if (tmr_exp) begin
                    d.st   = S_IDLE;
                    d.done = 1'b1;
                    d.code = CODE_STALL;
                end
            end
            S_LBA: begin
                tf_wr = 1'b1;
                case (q.sub)
                    3'd0:    begin tf_addr = REG_DRV;   tf_wdata = 8'hE0;         end
                    3'd1:    begin tf_addr = REG_LBA2;  tf_wdata = q.lba[23:16];  end
                    3'd2:    begin tf_addr = REG_LBA1;  tf_wdata = q.lba[15:8];   end
                    3'd3:    begin tf_addr = REG_LBA0;  tf_wdata = q.lba[7:0];    end
                    default: begin tf_addr = REG_COUNT; tf_wdata = 8'h01;         end
                endcase
                d.sub = q.sub + 3'd1;
                if (q.sub == 3'd4) d.st = S_CMD;
            end
            S_CMD: begin
                tf_wr    = 1'b1;
                tf_wdata = q.wr_op ? CMD_WRITE : CMD_READ;
                d.st     = S_WAIT;
                d.aft    = A_DRQ;
            end
            S_XFER: begin
                tf_addr = REG_DATA;
                if (q.wr_op) begin
                    buf_rd   = 1'b1;
                    tf_wr    = 1'b1;
                    tf_wdata = buf_rdata;
                end else begin
                    tf_rd  = 1'b1;
                    buf_wr = 1'b1;
                end
                d.idx = q.idx + AW'(1);
                if (q.idx == AW'(SECTOR_BYTES - 1)) begin
                    if (q.wr_op) begin
                        d.st  = S_WAIT;
                        d.aft = A_POST;
                    end else begin
                        d.st   = S_IDLE;
                        d.done = 1'b1;
                        d.ok   = 1'b1;
                    end
                end
            end
            S_ERRRD: begin
                tf_rd   = 1'b1;
                tf_addr = REG_FEAT;
                d.st    = S_IDLE;
                d.done  = 1'b1;
                d.code  = (tf_rdata == 8'h00) ? CODE_ZERO_ERR : tf_rdata;
            end
            default: d.st = S_IDLE;
        endcase
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            q <= '{st: S_IDLE, aft: A_FEAT1, default: '0};
        end else begin
            q <= d;
        end
    end

    assign busy     = (q.st != S_IDLE);
    assign done     = q.done;
    assign ok       = q.ok;
    assign err_code = q.code;
endmodule

// File: rtl/ata_xfer_ctrl_chk.sv
module ata_xfer_ctrl_chk (
    input logic       clk,
    input logic       rst_n,
    input logic       busy,
    input logic       done,
    input logic       ok,
    input logic [7:0] err_code,
    input logic [2:0] tf_addr,
    input logic       tf_wr,
    input logic       tf_rd,
    input logic [8:0] buf_addr,
    input logic       buf_wr,
    input logic       buf_rd
);
    assert_quiet_idle_R11: assert property (@(posedge clk) disable iff (!rst_n)
        !busy |-> !(tf_wr || tf_rd || buf_wr || buf_rd));

    assert_done_pulse_R11: assert property (@(posedge clk) disable iff (!rst_n)
        done |=> !done);

    assert_fail_nonzero_R8: assert property (@(posedge clk) disable iff (!rst_n)
        (done && !ok) |-> (err_code != 8'h00));

    assert_ok_clean_R6: assert property (@(posedge clk) disable iff (!rst_n)
        (done && ok) |-> (err_code == 8'h00));

    assert_buf_step_R5: assert property (@(posedge clk) disable iff (!rst_n)
        (buf_wr && $past(buf_wr)) |-> (buf_addr == $past(buf_addr) + 9'd1));

    assert_read_pair_R5: assert property (@(posedge clk) disable iff (!rst_n)
        buf_wr |-> (tf_rd && tf_addr == 3'd0));

    assert_write_pair_R6: assert property (@(posedge clk) disable iff (!rst_n)
        (tf_wr && tf_addr == 3'd0) |-> buf_rd);

    assert_one_strobe_R4: assert property (@(posedge clk) disable iff (!rst_n)
        !(tf_wr && tf_rd));
endmodule

bind ata_xfer_ctrl ata_xfer_ctrl_chk u_chk (
    .clk      (clk),
    .rst_n    (rst_n),
    .busy     (busy),
    .done     (done),
    .ok       (ok),
    .err_code (err_code),
    .tf_addr  (tf_addr),
    .tf_wr    (tf_wr),
    .tf_rd    (tf_rd),
    .buf_addr (buf_addr),
    .buf_wr   (buf_wr),
    .buf_rd   (buf_rd)
);

// File: tb/ata_xfer_ctrl_test.sv
module ata_xfer_ctrl_test;
    localparam int GAP  = 4;
    localparam int WLIM = 40;

    logic clk = 1'b0;
    logic rst_n;
    logic start;
    logic [1:0] op;
    logic [31:0] block;
    logic busy, done, ok;
    logic [7:0] err_code;
    logic [2:0] tf_addr;
    logic tf_wr, tf_rd;
    logic [7:0] tf_wdata, tf_rdata;
    logic [8:0] buf_addr;
    logic buf_wr, buf_rd;
    logic [7:0] buf_wdata, buf_rdata;

    always #2.5 clk = ~clk;

    ata_xfer_ctrl #(.POLL_GAP(GAP), .WAIT_LIMIT(WLIM)) uut (
        .clk(clk), .rst_n(rst_n), .start(start), .op(op), .block(block),
        .busy(busy), .done(done), .ok(ok), .err_code(err_code),
        .tf_addr(tf_addr), .tf_wr(tf_wr), .tf_rd(tf_rd),
        .tf_wdata(tf_wdata), .tf_rdata(tf_rdata),
        .buf_addr(buf_addr), .buf_wr(buf_wr), .buf_wdata(buf_wdata),
        .buf_rd(buf_rd), .buf_rdata(buf_rdata)
    );

    int checks = 0;
    int failures = 0;

    // test configuration of the device model
    logic never_ready = 0, inj_err = 0, no_drq = 0, post_err = 0;
    logic [7:0] err_val = 8'h00;

    // behavioural device
    int bsy_cnt, pend, rd_cnt, wr_cnt;
    logic drq, derr;
    logic [7:0] dev_store [512];
    logic [7:0] wbuf [512];
    logic [7:0] rmem [512];

    function automatic logic [7:0] pat(int i);
        return 8'((i * 7) + ((i >> 8) * 13) + 1);
    endfunction

    always @(posedge clk) begin
        if (!rst_n) begin
            bsy_cnt <= 0; pend <= 0; rd_cnt <= 0; wr_cnt <= 0;
            drq <= 1'b0; derr <= 1'b0;
        end else if (tf_wr && tf_addr == 3'd7) begin
            bsy_cnt <= 3; drq <= 1'b0; derr <= 1'b0;
            rd_cnt <= 0; wr_cnt <= 0;
            pend <= (tf_wdata == 8'h20 || tf_wdata == 8'h30) ? 1 : 0;
        end else begin
            if (bsy_cnt > 0) bsy_cnt <= bsy_cnt - 1;
            if (bsy_cnt == 1 && pend == 1) begin
                drq <= !no_drq; derr <= inj_err;
            end
            if (bsy_cnt == 1 && pend == 2) derr <= post_err;
            if (tf_rd && tf_addr == 3'd0) begin
                rd_cnt <= rd_cnt + 1;
                if (rd_cnt == 511) drq <= 1'b0;
            end
            if (tf_wr && tf_addr == 3'd0) begin
                dev_store[wr_cnt] <= tf_wdata;
                wr_cnt <= wr_cnt + 1;
                if (wr_cnt == 511) begin
                    drq <= 1'b0; bsy_cnt <= 3; pend <= 2;
                end
            end
        end
    end

    always_comb begin
        case (tf_addr)
            3'd0:    tf_rdata = pat(rd_cnt);
            3'd1:    tf_rdata = err_val;
            3'd7:    tf_rdata = {bsy_cnt != 0, !never_ready, 2'b00, drq, 2'b00, derr};
            default: tf_rdata = 8'h00;
        endcase
    end

    assign buf_rdata = wbuf[buf_addr];

    // reference sequence of control writes, compared every clock
    logic [10:0] exp_q [$];
    int seq_err = 0, addr_err = 0, xfer_cnt = 0, xfer_idx = 0;
    int poll_cnt = 0, gap_err = 0, cyc = 0, last_poll = 0;
    bit ipoll = 0;

    always @(negedge clk) begin
        cyc++;
        if (rst_n) begin
            if (tf_wr && tf_addr != 3'd0) begin
                if (exp_q.size() == 0 || exp_q[0] != {tf_addr, tf_wdata}) seq_err++;
                else void'(exp_q.pop_front());
                if (tf_addr == 3'd7) xfer_idx = 0;
                if (tf_addr == 3'd7 && tf_wdata == 8'hE1) begin
                    ipoll = 1; poll_cnt = 0;
                end
                if (tf_addr == 3'd1) ipoll = 0;
            end
            if (ipoll && tf_rd && tf_addr == 3'd7) begin
                if (poll_cnt > 0 && cyc - last_poll != GAP + 1) gap_err++;
                last_poll = cyc;
                poll_cnt++;
            end
            if (buf_wr || buf_rd) begin
                if (int'(buf_addr) != xfer_idx) addr_err++;
                xfer_idx++;
                xfer_cnt++;
            end
            if (buf_wr) rmem[buf_addr] = buf_wdata;
        end
    end

    task automatic check(input bit cond, input string tag, input int act, input int exp);
        checks++;
        if (!cond) begin
            failures++;
            $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
        end
    endtask

    task automatic push_lba(input logic [31:0] b, input logic [7:0] cmd);
        exp_q.push_back({3'd6, 8'hE0});
        exp_q.push_back({3'd5, b[23:16]});
        exp_q.push_back({3'd4, b[15:8]});
        exp_q.push_back({3'd3, b[7:0]});
        exp_q.push_back({3'd2, 8'h01});
        exp_q.push_back({3'd7, cmd});
    endtask

    task automatic run_op(input logic [1:0] o, input logic [31:0] b,
                          input bit exp_ok, input logic [7:0] exp_code,
                          input string tag, input string seq_tag);
        int se0 = seq_err;
        int n = 0;
        @(negedge clk);
        start = 1'b1; op = o; block = b;
        @(negedge clk);
        start = 1'b0;
        check(busy == 1'b1, "R11 busy after start", int'(busy), 1);
        while (!done && n < 20000) begin
            @(negedge clk);
            n++;
        end
        check(done == 1'b1, {tag, " done seen"}, int'(done), 1);
        check(ok == exp_ok, {tag, " ok"}, int'(ok), int'(exp_ok));
        check(err_code == exp_code, {tag, " err_code"}, int'(err_code), int'(exp_code));
        check(seq_err == se0 && exp_q.size() == 0, {seq_tag, " control write order"},
              seq_err - se0 + exp_q.size(), 0);
        exp_q.delete();
        @(negedge clk);
        check(done == 1'b0 && busy == 1'b0, "R11 done single pulse", int'({done, busy}), 0);
    endtask

    task automatic finish_run();
        $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
        $finish;
    endtask

    initial begin
        repeat (150000) @(posedge clk);
        failures++;
        $display("FAIL watchdog expired actual=0 expected=1");
        finish_run();
    end

    initial begin
        int x0, bad;
        rst_n = 1'b0; start = 1'b0; op = 2'd0; block = 32'h0;
        for (int i = 0; i < 512; i++) wbuf[i] = 8'(i * 3) ^ 8'h5A;
        repeat (4) @(negedge clk);
        check(!busy && !done && !ok && err_code == 8'h00, "R1 reset outputs",
              int'({busy, done, ok, err_code}), 0);
        check(!tf_wr && !tf_rd && !buf_wr && !buf_rd, "R1 reset strobes",
              int'({tf_wr, tf_rd, buf_wr, buf_rd}), 0);
        rst_n = 1'b1;
        @(negedge clk);

        // R2 init success
        exp_q.push_back({3'd7, 8'hE1});
        exp_q.push_back({3'd1, 8'h01});
        exp_q.push_back({3'd7, 8'hEF});
        exp_q.push_back({3'd1, 8'h82});
        exp_q.push_back({3'd7, 8'hEF});
        run_op(2'd0, 32'h0, 1'b1, 8'h00, "R2 init", "R2");

        // R4 R5 read, top byte ignored
        push_lba(32'hA5123456, 8'h20);
        x0 = xfer_cnt;
        run_op(2'd1, 32'hA5123456, 1'b1, 8'h00, "R5 read", "R4");
        check(xfer_cnt - x0 == 512 && addr_err == 0, "R5 buffer addresses 0..511",
              xfer_cnt - x0, 512);
        bad = 0;
        for (int i = 0; i < 512; i++) if (rmem[i] != pat(i)) bad++;
        check(bad == 0, "R5 read data", bad, 0);

        // R6 write
        push_lba(32'h000001FF, 8'h30);
        run_op(2'd2, 32'h000001FF, 1'b1, 8'h00, "R6 write", "R4");
        bad = 0;
        for (int i = 0; i < 512; i++) if (dev_store[i] != wbuf[i]) bad++;
        check(bad == 0 && wr_cnt == 512, "R6 device received buffer", bad, 0);

        // R7 error with data-request
        inj_err = 1'b1; err_val = 8'h04;
        push_lba(32'h00000010, 8'h20);
        x0 = xfer_cnt;
        run_op(2'd1, 32'h00000010, 1'b0, 8'h04, "R7 read error", "R4");
        check(xfer_cnt == x0, "R7 no data moved", xfer_cnt - x0, 0);

        // R8 zero error register
        err_val = 8'h00;
        push_lba(32'h00000011, 8'h20);
        run_op(2'd1, 32'h00000011, 1'b0, 8'hFF, "R8 zero error reg", "R4");
        inj_err = 1'b0;

        // R9 error after write data phase
        post_err = 1'b1; err_val = 8'h10;
        push_lba(32'h00ABCDEF, 8'h30);
        run_op(2'd2, 32'h00ABCDEF, 1'b0, 8'h10, "R9 post-write error", "R4");
        check(wr_cnt == 512, "R9 all bytes written first", wr_cnt, 512);
        post_err = 1'b0;

        // R10 data-request never comes
        no_drq = 1'b1;
        push_lba(32'h00000020, 8'h20);
        run_op(2'd1, 32'h00000020, 1'b0, 8'hFD, "R10 stall", "R4");
        no_drq = 1'b0;

        // R3 init gives up
        never_ready = 1'b1;
        exp_q.push_back({3'd7, 8'hE1});
        run_op(2'd0, 32'h0, 1'b0, 8'hFE, "R3 init timeout", "R3");
        check(poll_cnt == 256, "R3 poll count", poll_cnt, 256);
        check(gap_err == 0, "R3 poll spacing", gap_err, 0);
        never_ready = 1'b0;

        finish_run();
    end
endmodule